// File: doc/BRIEF.md
# NOR Flash Write-Command Decoder

This block is the command state machine of one 16-bit parallel NOR flash bank. Each bus write cycle presents an address and a data word. The decoder matches these writes against multi-cycle command sequences. It starts standard programming and sector or chip erase. It enters and leaves a faster unlock bypass mode, and it switches reads over to identification words or to a read-only secured serial-number region.

A simple program/erase engine holds the bank busy for a fixed number of clock cycles. When that count expires, it commits the result to a small behavioural cell array. Programming can only clear bits. While the engine runs, every write is discarded. Reads are combinational from the address. Depending on the mode flags, they return array words, identification words or secured-region words.

All unlock cycles use data AAh at word address 555h, followed by data 55h at word address 2AAh. Only the low byte of a command write is decoded.

Top module: `nor_cmd_decoder`

## Requirements
- R1: During and right after a synchronous active-low reset, `ready` is 1, no sequence is in progress, every mode flag is clear and every array word reads FFFFh.
- R2: A standard program is the four writes AAh@555h, 55h@2AAh, A0h@555h, then data@target. `ready` is 0 for exactly BUSY_PROG cycles, starting the cycle after the final write, and the target then reads the new value.
- R3: A program stores the old word AND the written word, so a 0 bit never returns to 1 through programming.
- R4: A write whose address or data does not match the expected cycle abandons the sequence. The following writes start from the idle state, so the rest of the broken sequence has no effect.
- R5: AAh@555h, 55h@2AAh, 20h@555h enters unlock bypass mode. In that mode a program is only A0h (any address) followed by data@target, with the same busy time as R2.
- R6: In bypass mode the decoder recognises only A0h, 80h and 90h as a first cycle. Every other write, including F0h and unlock cycles, is ignored, so autoselect cannot be entered. 90h then 00h (any addresses) leaves bypass mode, after which A0h alone no longer starts a program.
- R7: Erase is 80h@555h after two unlocks, then AAh@555h, 55h@2AAh, then 30h@sector address (sector erase) or 10h@555h (chip erase): six writes. In bypass mode the same sequence starts at 80h (any address) and takes four writes. `ready` is 0 for BUSY_ERASE cycles, and then the erased words read FFFFh.
- R8: A program or sector erase aimed at a sector whose bit in PROT_MASK is 1 starts nothing (`ready` stays 1). A chip erase leaves protected sectors untouched.
- R9: While `ready` is 0, every write is ignored and changes no sequence state or mode.
- R10: A reset during a busy operation ends it at once. `ready` is 1 right after reset, and the pending write is never committed.
- R11: AAh@555h, 55h@2AAh, 90h@555h enters autoselect. Reads then decode the low address nibble: 0h gives MFR_ID, 1h gives DEV_ID0, Eh gives DEV_ID1 and Fh gives DEV_ID2. 2h gives 0001h if the addressed sector is protected and 0000h otherwise. F0h at any address returns to array reads.
- R12: AAh@555h, 55h@2AAh, 88h@555h overlays the secured region. Reads then return word i = C0DEh XOR {i,i} as bytes, with i taken from address bits 2:0. The sequence AAh@555h, 55h@2AAh, 90h@555h, 00h@any removes the overlay. While `ready` is 0, reads bypass the overlay and return array data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Bus write strobe, one write per cycle |
| addr | input | ADDR_W | Word address for writes and reads |
| wdata | input | 16 | Write data word |
| rdata | output | 16 | Read data for `addr` (combinational) |
| ready | output | 1 | 1 when no program or erase is running |

## Verification
The bound checker watches, on every cycle, the rules that cover the whole bus:
- writes during a busy phase leave the sequence state and mode flags unchanged;
- an operation is started only while the bank is ready;
- bypass mode and autoselect are never active together;
- a bypass entry write always sets the mode;
- a busy phase never outlasts the longest configured time.

Only the bench scenarios can show the data results: AND programming, erase fill values, the exact busy length per operation, protected-sector refusal, the identification and secured-region words, and the loss of a pending program on reset.

// File: rtl/nor_cmd_pkg.sv
// Shared types and command codes for the NOR command decoder.
// Assumes word-addressed unlock locations that fit in 11 bits.
package nor_cmd_pkg;

    typedef enum logic [3:0] {
        SQ_IDLE,   // idle (array read, or bypass idle when bypass flag set)
        SQ_UNL1,   // first unlock cycle seen
        SQ_UNL2,   // both unlock cycles seen
        SQ_PROG,   // waiting for program address/data
        SQ_ERS1,   // erase setup seen
        SQ_ERS2,   // erase setup + first unlock seen
        SQ_ERS3,   // erase setup + both unlocks seen
        SQ_SECX,   // secured exit: waiting for final 00h
        SQ_BYPR    // bypass reset: waiting for final 00h
    } seq_t;

    typedef enum logic [1:0] {
        PE_PROG,
        PE_SECT,
        PE_CHIP
    } pe_op_t;

    localparam logic [10:0] UNLOCK_ADDR_A = 11'h555;
    localparam logic [10:0] UNLOCK_ADDR_B = 11'h2AA;

    localparam logic [7:0] CMD_UNL_A  = 8'hAA;
    localparam logic [7:0] CMD_UNL_B  = 8'h55;
    localparam logic [7:0] CMD_PROG   = 8'hA0;
    localparam logic [7:0] CMD_BYPASS = 8'h20;
    localparam logic [7:0] CMD_ERASE  = 8'h80;
    localparam logic [7:0] CMD_CHIP   = 8'h10;
    localparam logic [7:0] CMD_SECT   = 8'h30;
    localparam logic [7:0] CMD_IDREAD = 8'h90;
    localparam logic [7:0] CMD_SECURE = 8'h88;
    localparam logic [7:0] CMD_RESET  = 8'hF0;
    localparam logic [7:0] CMD_ZERO   = 8'h00;

    // Secured-region content: fixed serial pattern computed per index.
    function automatic logic [15:0] secured_word(input logic [2:0] idx);
        return 16'hC0DE ^ {5'b0, idx, 5'b0, idx};
    endfunction

endpackage

// File: rtl/nor_seq_fsm.sv
// Write-sequence tracker. Matches bus writes against the command
// sequences, keeps the bypass, autoselect and secured-overlay flags,
// and issues a one-cycle start with operation, target and data.
// Assumes the caller holds `ready` low while an operation runs; all
// writes are discarded in that time.
module nor_seq_fsm
    import nor_cmd_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int ARR_AW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       wdata,
    input  logic              ready,
    output seq_t              state,
    output logic              bypass_mode,
    output logic              autosel_mode,
    output logic              secure_mode,
    output logic              start,
    output pe_op_t            op,
    output logic [ARR_AW-1:0] tgt_addr,
    output logic [15:0]       tgt_data
);

    localparam logic [ADDR_W-1:0] ADDR_A = ADDR_W'(UNLOCK_ADDR_A);
    localparam logic [ADDR_W-1:0] ADDR_B = ADDR_W'(UNLOCK_ADDR_B);

    seq_t       nxt_state;
    logic       nxt_byp, nxt_auto, nxt_sec;
    logic       accept, at_a, at_b;
    logic [7:0] cmd;

    assign accept   = wr_en && ready;
    assign at_a     = (addr == ADDR_A);
    assign at_b     = (addr == ADDR_B);
    assign cmd      = wdata[7:0];
    assign tgt_addr = addr[ARR_AW-1:0];
    assign tgt_data = wdata;

    // Next-state and start decode for one accepted write.
    always_comb begin
        nxt_state = state;
        nxt_byp   = bypass_mode;
        nxt_auto  = autosel_mode;
        nxt_sec   = secure_mode;
        start     = 1'b0;
        op        = PE_PROG;
        if (accept) begin
            nxt_state = SQ_IDLE;
            case (state)
                SQ_IDLE: begin
                    if (bypass_mode) begin
                        if (cmd == CMD_PROG)        nxt_state = SQ_PROG;
                        else if (cmd == CMD_ERASE)  nxt_state = SQ_ERS1;
                        else if (cmd == CMD_IDREAD) nxt_state = SQ_BYPR;
                    end else begin
                        if (cmd == CMD_UNL_A && at_a) nxt_state = SQ_UNL1;
                        else if (cmd == CMD_RESET)    nxt_auto  = 1'b0;
                    end
                end
                SQ_UNL1: begin
                    if (cmd == CMD_UNL_B && at_b) nxt_state = SQ_UNL2;
                end
                SQ_UNL2: begin
                    if (at_a) begin
                        case (cmd)
                            CMD_PROG:   nxt_state = SQ_PROG;
                            CMD_ERASE:  nxt_state = SQ_ERS1;
                            CMD_BYPASS: begin
                                nxt_byp  = 1'b1;
                                nxt_auto = 1'b0;
                            end
                            CMD_IDREAD: begin
                                if (secure_mode) nxt_state = SQ_SECX;
                                else             nxt_auto  = 1'b1;
                            end
                            CMD_SECURE: nxt_sec = 1'b1;
                            default:    nxt_state = SQ_IDLE;
                        endcase
                    end
                end
                SQ_PROG: begin
                    start = 1'b1;
                    op    = PE_PROG;
                end
                SQ_ERS1: begin
                    if (cmd == CMD_UNL_A && at_a) nxt_state = SQ_ERS2;
                end
                SQ_ERS2: begin
                    if (cmd == CMD_UNL_B && at_b) nxt_state = SQ_ERS3;
                end
                SQ_ERS3: begin
                    if (cmd == CMD_CHIP && at_a) begin
                        start = 1'b1;
                        op    = PE_CHIP;
                    end else if (cmd == CMD_SECT) begin
                        start = 1'b1;
                        op    = PE_SECT;
                    end
                end
                SQ_SECX: begin
                    if (cmd == CMD_ZERO) nxt_sec = 1'b0;
                end
                SQ_BYPR: begin
                    if (cmd == CMD_ZERO) nxt_byp = 1'b0;
                end
                default: nxt_state = SQ_IDLE;
            endcase
        end
    end

    // State and mode flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= SQ_IDLE;
            bypass_mode  <= 1'b0;
            autosel_mode <= 1'b0;
            secure_mode  <= 1'b0;
        end else begin
            state        <= nxt_state;
            bypass_mode  <= nxt_byp;
            autosel_mode <= nxt_auto;
            secure_mode  <= nxt_sec;
        end
    end

endmodule

// File: rtl/nor_pe_engine.sv
// Program/erase engine. Accepts a start when the target sector is not
// protected (chip erase is always accepted), stays busy for a fixed
// count per operation, then pulses commit with the latched job.
// Assumes start arrives only while not busy.
module nor_pe_engine
    import nor_cmd_pkg::*;
#(
    parameter int ARR_AW     = 6,
    parameter int SEC_AW     = 4,
    parameter int BUSY_PROG  = 8,
    parameter int BUSY_ERASE = 20,
    parameter logic [(1<<(ARR_AW-SEC_AW))-1:0] PROT_MASK = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  pe_op_t            op,
    input  logic [ARR_AW-1:0] addr,
    input  logic [15:0]       data,
    output logic              busy,
    output logic              commit,
    output pe_op_t            c_op,
    output logic [ARR_AW-1:0] c_addr,
    output logic [15:0]       c_data
);

    localparam int MAX_BUSY = (BUSY_ERASE > BUSY_PROG) ? BUSY_ERASE : BUSY_PROG;
    localparam int CNT_W    = $clog2(MAX_BUSY + 1);

    logic [CNT_W-1:0] cnt;
    logic             allowed;

    assign allowed = (op == PE_CHIP) || !PROT_MASK[addr[ARR_AW-1:SEC_AW]];
    assign commit  = busy && (cnt == '0);

    // Busy counter and job latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            cnt    <= '0;
            c_op   <= PE_PROG;
            c_addr <= '0;
            c_data <= '0;
        end else if (start && allowed && !busy) begin
            busy   <= 1'b1;
            cnt    <= (op == PE_PROG) ? CNT_W'(BUSY_PROG - 1) : CNT_W'(BUSY_ERASE - 1);
            c_op   <= op;
            c_addr <= addr;
            c_data <= data;
        end else if (commit) begin
            busy <= 1'b0;
        end else if (busy) begin
            cnt <= cnt - 1'b1;
        end
    end

endmodule

// File: rtl/nor_cell_array.sv
// Behavioural cell array. Program ANDs data into one word, sector erase
// fills one sector with ones, chip erase fills every unprotected sector.
// Reset restores the erased state. Read is combinational.
module nor_cell_array
    import nor_cmd_pkg::*;
#(
    parameter int ARR_AW = 6,
    parameter int SEC_AW = 4,
    parameter logic [(1<<(ARR_AW-SEC_AW))-1:0] PROT_MASK = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  pe_op_t            c_op,
    input  logic [ARR_AW-1:0] c_addr,
    input  logic [15:0]       c_data,
    input  logic [ARR_AW-1:0] rd_addr,
    output logic [15:0]       rd_word
);

    localparam int WORDS = 1 << ARR_AW;

    logic [15:0] mem [WORDS];

    generate
        for (genvar w = 0; w < WORDS; w++) begin : g_word
            localparam logic [ARR_AW-1:0] WA = ARR_AW'(w);
            localparam int SEC = w >> SEC_AW;
            // Update of one word on commit.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    mem[w] <= 16'hFFFF;
                end else if (commit) begin
                    if (c_op == PE_PROG && c_addr == WA)
                        mem[w] <= mem[w] & c_data;
                    else if (c_op == PE_SECT && c_addr[ARR_AW-1:SEC_AW] == WA[ARR_AW-1:SEC_AW])
                        mem[w] <= 16'hFFFF;
                    else if (c_op == PE_CHIP && !PROT_MASK[SEC])
                        mem[w] <= 16'hFFFF;
                end
            end
        end
    endgenerate

    assign rd_word = mem[rd_addr];

endmodule

// File: rtl/nor_read_mux.sv
// Read data selection: array while busy or in normal mode, secured
// words when the overlay is active, identification words in autoselect.
module nor_read_mux
    import nor_cmd_pkg::*;
#(
    parameter int ARR_AW = 6,
    parameter int SEC_AW = 4,
    parameter logic [(1<<(ARR_AW-SEC_AW))-1:0] PROT_MASK = '0,
    parameter logic [15:0] MFR_ID  = 16'h0001,
    parameter logic [15:0] DEV_ID0 = 16'h2A10,
    parameter logic [15:0] DEV_ID1 = 16'h2A21,
    parameter logic [15:0] DEV_ID2 = 16'h2A00
) (
    input  logic [ARR_AW-1:0] addr,
    input  logic              busy,
    input  logic              secure_mode,
    input  logic              autosel_mode,
    input  logic [15:0]       arr_word,
    output logic [15:0]       rdata
);

    logic [15:0] id_word;

    // Identification word decode on the low address nibble.
    always_comb begin
        case (addr[3:0])
            4'h0:    id_word = MFR_ID;
            4'h1:    id_word = DEV_ID0;
            4'h2:    id_word = {15'b0, PROT_MASK[addr[ARR_AW-1:SEC_AW]]};
            4'hE:    id_word = DEV_ID1;
            4'hF:    id_word = DEV_ID2;
            default: id_word = 16'h0000;
        endcase
    end

    // Source selection by mode.
    always_comb begin
        if (busy)              rdata = arr_word;
        else if (secure_mode)  rdata = secured_word(addr[2:0]);
        else if (autosel_mode) rdata = id_word;
        else                   rdata = arr_word;
    end

endmodule

// File: rtl/nor_cmd_decoder.sv
// Top of the NOR bank command decoder: sequence tracker, program/erase
// engine, cell array and read multiplexer. One write per cycle; reads
// are combinational from addr. Requires ADDR_W >= 11 and ARR_AW > SEC_AW >= 4.
module nor_cmd_decoder
    import nor_cmd_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int ARR_AW     = 6,
    parameter int SEC_AW     = 4,
    parameter int BUSY_PROG  = 8,
    parameter int BUSY_ERASE = 20,
    parameter logic [(1<<(ARR_AW-SEC_AW))-1:0] PROT_MASK = 4'b0010,
    parameter logic [15:0] MFR_ID  = 16'h0001,
    parameter logic [15:0] DEV_ID0 = 16'h2A10,
    parameter logic [15:0] DEV_ID1 = 16'h2A21,
    parameter logic [15:0] DEV_ID2 = 16'h2A00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       wdata,
    output logic [15:0]       rdata,
    output logic              ready
);

    seq_t              seq_state;
    logic              bypass_mode, autosel_mode, secure_mode;
    logic              start, busy, commit;
    pe_op_t            op, c_op;
    logic [ARR_AW-1:0] tgt_addr, c_addr;
    logic [15:0]       tgt_data, c_data, arr_word;

    assign ready = !busy;

    nor_seq_fsm #(.ADDR_W(ADDR_W), .ARR_AW(ARR_AW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .ready(ready), .state(seq_state), .bypass_mode(bypass_mode),
        .autosel_mode(autosel_mode), .secure_mode(secure_mode), .start(start),
        .op(op), .tgt_addr(tgt_addr), .tgt_data(tgt_data)
    );

    nor_pe_engine #(
        .ARR_AW(ARR_AW), .SEC_AW(SEC_AW), .BUSY_PROG(BUSY_PROG),
        .BUSY_ERASE(BUSY_ERASE), .PROT_MASK(PROT_MASK)
    ) u_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .addr(tgt_addr),
        .data(tgt_data), .busy(busy), .commit(commit), .c_op(c_op),
        .c_addr(c_addr), .c_data(c_data)
    );

    nor_cell_array #(.ARR_AW(ARR_AW), .SEC_AW(SEC_AW), .PROT_MASK(PROT_MASK)) u_array (
        .clk(clk), .rst_n(rst_n), .commit(commit), .c_op(c_op), .c_addr(c_addr),
        .c_data(c_data), .rd_addr(addr[ARR_AW-1:0]), .rd_word(arr_word)
    );

    nor_read_mux #(
        .ARR_AW(ARR_AW), .SEC_AW(SEC_AW), .PROT_MASK(PROT_MASK), .MFR_ID(MFR_ID),
        .DEV_ID0(DEV_ID0), .DEV_ID1(DEV_ID1), .DEV_ID2(DEV_ID2)
    ) u_rmux (
        .addr(addr[ARR_AW-1:0]), .busy(busy), .secure_mode(secure_mode),
        .autosel_mode(autosel_mode), .arr_word(arr_word), .rdata(rdata)
    );

endmodule

// File: rtl/nor_cmd_decoder_chk.sv
// Protocol checker for nor_cmd_decoder, attached with bind below.
module nor_cmd_decoder_chk #(
    parameter int ADDR_W     = 12,
    parameter int BUSY_PROG  = 8,
    parameter int BUSY_ERASE = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [15:0]       wdata,
    input logic              ready,
    input logic              start,
    input logic [3:0]        state,
    input logic              bypass_mode,
    input logic              autosel_mode,
    input logic              secure_mode
);

    localparam int MAX_BUSY = (BUSY_ERASE > BUSY_PROG) ? BUSY_ERASE : BUSY_PROG;
    localparam logic [3:0] ST_UNL2 = 4'd2;

    logic [31:0] busy_run;

    // Length of the current busy phase.
    always_ff @(posedge clk) begin
        if (!rst_n)     busy_run <= '0;
        else if (!ready) busy_run <= busy_run + 1;
        else            busy_run <= '0;
    end

    assert_reset_ready_R1: assert property (@(posedge clk) !rst_n |=> ready);

    assert_busy_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy_run <= MAX_BUSY);

    assert_bypass_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_UNL2 && wr_en && ready && addr == ADDR_W'(11'h555)
         && wdata[7:0] == 8'h20) |=> bypass_mode);

    assert_modes_apart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bypass_mode, autosel_mode}));

    assert_ignore_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && wr_en) |=> ($stable(state) && $stable(bypass_mode)
                               && $stable(autosel_mode) && $stable(secure_mode)));

    assert_start_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> ready);

endmodule

bind nor_cmd_decoder nor_cmd_decoder_chk #(
    .ADDR_W(ADDR_W), .BUSY_PROG(BUSY_PROG), .BUSY_ERASE(BUSY_ERASE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .ready(ready), .start(start), .state(seq_state), .bypass_mode(bypass_mode),
    .autosel_mode(autosel_mode), .secure_mode(secure_mode)
);

// File: tb/nor_cmd_decoder_bench.sv
`timescale 1ns/1ps
module nor_cmd_decoder_bench;

    localparam int BP = 8;
    localparam int BE = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        ready;
    logic        rd_req = 1'b0;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [15:0] exp;
        string       tag;
    } exp_item_t;
    exp_item_t exp_q[$];

    always #5 clk = ~clk;

    nor_cmd_decoder u_nor_cmd_decoder (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .ready(ready)
    );

    // Monitor: pops expected read items and compares away from the edge.
    always @(posedge clk) begin
        #2;
        if (rd_req) begin
            exp_item_t it;
            it = exp_q.pop_front();
            checks++;
            if (rdata !== it.exp) begin
                errors++;
                $display("FAIL %s: rdata actual %h expected %h", it.tag, rdata, it.exp);
            end
        end
    end

    task automatic check_val(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Driver: a read pushes its expected word for the monitor.
    task automatic rd(input logic [11:0] a, input logic [15:0] e, input string tag);
        exp_item_t it;
        @(negedge clk);
        wr_en = 1'b0;
        addr  = a;
        it.exp = e;
        it.tag = tag;
        exp_q.push_back(it);
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        addr  = a;
        wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic unlock();
        wr(12'h555, 16'h00AA);
        wr(12'h2AA, 16'h0055);
    endtask

    // Counts busy cycles from the negedge after the last write.
    task automatic busy_len(output int n);
        n = 0;
        while (!ready) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check_val(ready, 1, "R1 ready after reset");
        rd(12'h000, 16'hFFFF, "R1 erased word after reset");

        // R2: standard program
        unlock(); wr(12'h555, 16'h00A0); wr(12'h005, 16'h1234);
        busy_len(n);
        check_val(n, BP, "R2 program busy length");
        rd(12'h005, 16'h1234, "R2 programmed word");

        // R3: AND programming
        unlock(); wr(12'h555, 16'h00A0); wr(12'h005, 16'h0F0F);
        busy_len(n);
        rd(12'h005, 16'h0204, "R3 AND of old and new");

        // R4: broken sequence
        wr(12'h555, 16'h00AA); wr(12'h2AB, 16'h0055);
        wr(12'h555, 16'h00A0); wr(12'h006, 16'h0000);
        check_val(ready, 1, "R4 no busy after broken sequence");
        rd(12'h006, 16'hFFFF, "R4 word untouched");

        // R11: autoselect
        unlock(); wr(12'h555, 16'h0090);
        rd(12'h000, 16'h0001, "R11 manufacturer");
        rd(12'h001, 16'h2A10, "R11 device word 0");
        rd(12'h00E, 16'h2A21, "R11 device word 1");
        rd(12'h00F, 16'h2A00, "R11 device word 2");
        rd(12'h012, 16'h0001, "R11 protected sector status");
        rd(12'h002, 16'h0000, "R11 unprotected sector status");
        wr(12'h123, 16'h00F0);
        rd(12'h005, 16'h0204, "R11 F0 returns to array");

        // R12: secured overlay
        unlock(); wr(12'h555, 16'h0088);
        rd(12'h000, 16'hC0DE, "R12 secured word 0");
        rd(12'h003, 16'hC3DD, "R12 secured word 3");
        unlock(); wr(12'h555, 16'h00A0); wr(12'h007, 16'h00FF);
        rd(12'h005, 16'h0204, "R12 array visible while busy");
        busy_len(n);
        rd(12'h000, 16'hC0DE, "R12 overlay back after busy");
        unlock(); wr(12'h555, 16'h0090); wr(12'h000, 16'h0000);
        rd(12'h007, 16'h00FF, "R12 exit restores array");

        // R5: bypass entry and short program
        unlock(); wr(12'h555, 16'h0020);
        wr(12'h000, 16'h00A0); wr(12'h008, 16'hABCD);
        busy_len(n);
        check_val(n, BP, "R5 bypass program busy length");
        rd(12'h008, 16'hABCD, "R5 bypass program word");

        // R6: bypass ignores other commands
        wr(12'h000, 16'h00F0);
        wr(12'h000, 16'h00A0); wr(12'h00A, 16'h5555);
        busy_len(n);
        rd(12'h00A, 16'h5555, "R6 still bypass after F0");
        unlock(); wr(12'h555, 16'h0090);
        rd(12'h000, 16'hFFFF, "R6 no autoselect in bypass");
        wr(12'h000, 16'h0000);
        wr(12'h000, 16'h00A0); wr(12'h009, 16'h0000);
        check_val(ready, 1, "R6 A0 alone ignored after bypass exit");
        rd(12'h009, 16'hFFFF, "R6 bypass exit word untouched");

        // R7: four-cycle bypass sector erase
        unlock(); wr(12'h555, 16'h0020);
        wr(12'h000, 16'h0080); unlock(); wr(12'h008, 16'h0030);
        busy_len(n);
        check_val(n, BE, "R7 erase busy length");
        rd(12'h008, 16'hFFFF, "R7 sector erased word 8");
        rd(12'h005, 16'hFFFF, "R7 sector erased word 5");
        wr(12'h000, 16'h0090); wr(12'h000, 16'h0000);

        // R8: protected sector refuses program
        unlock(); wr(12'h555, 16'h00A0); wr(12'h013, 16'h0000);
        check_val(ready, 1, "R8 protected program refused");
        rd(12'h013, 16'hFFFF, "R8 protected word unchanged");

        // R7: six-cycle chip erase
        unlock(); wr(12'h555, 16'h00A0); wr(12'h023, 16'h0000);
        busy_len(n);
        rd(12'h023, 16'h0000, "R7 setup program");
        unlock(); wr(12'h555, 16'h0080); unlock(); wr(12'h555, 16'h0010);
        busy_len(n);
        check_val(n, BE, "R7 chip erase busy length");
        rd(12'h023, 16'hFFFF, "R7 chip erase fills ones");

        // R9: writes ignored while busy
        unlock(); wr(12'h555, 16'h00A0); wr(12'h030, 16'h00F0);
        unlock(); wr(12'h555, 16'h0090);
        busy_len(n);
        rd(12'h000, 16'hFFFF, "R9 autoselect ignored while busy");
        rd(12'h030, 16'h00F0, "R9 program completed");

        // R10: reset aborts
        unlock(); wr(12'h555, 16'h00A0); wr(12'h031, 16'h0000);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check_val(ready, 1, "R10 ready right after reset");
        repeat (12) @(negedge clk);
        check_val(ready, 1, "R10 no late busy");
        rd(12'h031, 16'hFFFF, "R10 pending program dropped");

        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule